// File: doc/BRIEF.md
# Dual-lane sample serializer with framing

This block turns one parallel 14-bit conversion result per word period into a serial stream on one or two output lanes. It runs from a clock at twice the per-lane bit rate, so every bit slot takes two clock cycles. Alongside the data it produces a bit clock for the receiver and a frame marker that outlines each word. Mode pins choose one or two lanes, 14 or 16 bits per word, double-rate or single-rate bit clock with a chosen capture edge, and the bit order.

The word period length depends on the mode. A word is taken from `din_i` at the last edge of every frame. It goes through a fixed pipeline and is sent a set number of word periods later. The mode pins are sampled at that same frame edge, so each frame is sent from start to end under a single mode.

Top module: `ls_sample_serializer`

## Requirements
- R1: While `rst` is high, after at least one clock edge, `lane_o` is 0 and `frame_o` is 1.
- R2: A frame lasts P clock cycles, where P = 2·W/L. W is 14, or 16 when `wide_i`=1, and L is 1, or 2 when `two_lane_i`=1. `frame_o` is 1 for the first P/2 cycles and 0 for the last P/2.
- R3: In one-lane mode, bit slot i (cycles 2i and 2i+1 of the frame) carries bit s[i] on `lane_o[0]`, and `lane_o[1]` stays 0.
- R4: In two-lane mode, bit slot i carries s[2i] on `lane_o[0]` and s[2i+1] on `lane_o[1]`.
- R5: The ordered word is s[j] = d[13-j] when `msb_first_i`=1 and s[j] = d[j] when it is 0, for j < 14.
- R6: In 16-bit mode, s[14] and s[15] are both 0.
- R7: A value on `din_i` at the last edge of frame f is sent during frame f+13, which starts 12 word periods after that edge. Frames 0 to 12 after reset send a zero word.
- R8: With the double-rate bit clock, `bclk_o` is 0 in the first cycle after reset. It changes only on the edge into the second cycle of each bit slot, and `lane_o` changes only on the edge into the first cycle of a slot.
- R9: The single-rate bit clock applies only when `sdr_i`=1 and `two_lane_i`=1. With `rise_cap_i`=1, `bclk_o` is 0 in the first cycle of each slot and 1 in the second. With `rise_cap_i`=0 it is the reverse. When `sdr_i`=1 in one-lane mode, the R8 clock is used.
- R10: Mode pins are sampled only at the last edge of a frame. A change during a frame has no effect on that frame, and only the value present at that edge applies to the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the per-lane bit rate |
| rst | input | 1 | Synchronous reset, active high; also loads the mode pins |
| din_i | input | 14 | Parallel sample, taken at the last edge of each frame |
| two_lane_i | input | 1 | 1: word split over two lanes; 0: one lane |
| wide_i | input | 1 | 1: 16 bits per word (two zero pad bits); 0: 14 |
| sdr_i | input | 1 | 1: single-rate bit clock (two-lane only); 0: double-rate |
| rise_cap_i | input | 1 | Single-rate capture edge: 1 rising, 0 falling |
| msb_first_i | input | 1 | 1: most significant bit first; 0: least significant first |
| lane_o | output | 2 | Serial data lanes |
| bclk_o | output | 1 | Bit clock for the receiver |
| frame_o | output | 1 | Frame marker, high for the first half of each word |

## Verification
At the last edge of a frame, three things happen in the same cycle. The mode pins are latched, a new sample is taken, and the oldest pipelined word is loaded for sending. The frame length, lane mapping and bit clock of the next frame therefore all depend on that one edge. The bench provokes this by driving a different mode early in a frame and the final mode two cycles later, frame after frame, while the serialized data stays live. Each cycle of every frame is compared with a model that uses the earlier frame's final pin value, so a premature latch or a word loaded from the wrong stage shows up as a wrong frame length or wrong lane bits.

// File: rtl/lvser_pkg.sv
`timescale 1ns/1ps
package lvser_pkg;

  localparam int LS_DATA_W  = 14;
  localparam int LS_PAD_W   = 2;
  localparam int LS_LATENCY = 12;

  typedef struct packed {
    logic two_lane;
    logic wide;
    logic sdr;
    logic rise_cap;
    logic msb_first;
  } ser_mode_t;

  // bits in one word for this mode
  function automatic int word_bits(ser_mode_t m, int dw, int pw);
    return m.wide ? dw + pw : dw;
  endfunction

  // bit slots per lane in one word
  function automatic int slots_per_word(ser_mode_t m, int dw, int pw);
    int b;
    b = word_bits(m, dw, pw);
    return m.two_lane ? (b + 1) / 2 : b;
  endfunction

  // clock cycles per frame: two per bit slot
  function automatic int frame_cycles(ser_mode_t m, int dw, int pw);
    return 2 * slots_per_word(m, dw, pw);
  endfunction

  function automatic logic sdr_active(ser_mode_t m);
    return m.sdr & m.two_lane;
  endfunction

endpackage

// File: rtl/ls_frame_timer.sv
`timescale 1ns/1ps
module ls_frame_timer
  import lvser_pkg::*;
#(
  parameter int DATA_W = LS_DATA_W,
  parameter int PAD_W  = LS_PAD_W,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  ser_mode_t        mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             frame_o,
  output logic             bclk_o,
  output logic             two_lane_o,
  output logic             msb_first_o,
  output logic             sdr_on_o,
  output logic             rise_cap_o
);

  localparam int LEN_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  ser_mode_t        mode_q;
  logic             ddr_q;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] half;

  always_comb begin
    len  = LEN_W'(frame_cycles(mode_q, DATA_W, PAD_W));
    half = len >> 1;
  end

  assign wrap_o  = ({1'b0, cnt_q} == (len - 1'b1));
  assign frame_o = ({1'b0, cnt_q} < half);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= mode_i;
      ddr_q  <= 1'b0;
    end else begin
      if (!cnt_q[0]) ddr_q <= ~ddr_q;
      if (wrap_o) begin
        cnt_q  <= '0;
        mode_q <= mode_i;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign sdr_on_o    = sdr_active(mode_q);
  assign rise_cap_o  = mode_q.rise_cap;
  assign two_lane_o  = mode_q.two_lane;
  assign msb_first_o = mode_q.msb_first;
  assign cnt_o       = cnt_q;
  assign bclk_o      = sdr_on_o ? (mode_q.rise_cap ? cnt_q[0] : ~cnt_q[0]) : ddr_q;

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_o |=> $stable(mode_q));

  // R8
  ddr_mid_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!sdr_on_o && cnt_q[0]) |-> (bclk_o != $past(bclk_o)));

endmodule

// File: rtl/ls_latency_pipe.sv
`timescale 1ns/1ps
module ls_latency_pipe
  import lvser_pkg::*;
#(
  parameter int DATA_W  = LS_DATA_W,
  parameter int LATENCY = LS_LATENCY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] word_o
);

  for (genvar gi = 0; gi < LATENCY; gi++) begin : g_stage
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] feed;
    if (gi == 0) begin : g_head
      assign feed = din_i;
    end else begin : g_body
      assign feed = g_stage[gi-1].q;
    end
    always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (load_i) q <= feed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         word_o <= '0;
    else if (load_i) word_o <= g_stage[LATENCY-1].q;
  end

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(word_o));

endmodule

// File: rtl/ls_lane_select.sv
`timescale 1ns/1ps
module ls_lane_select
  import lvser_pkg::*;
#(
  parameter int DATA_W = LS_DATA_W,
  parameter int PAD_W  = LS_PAD_W,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              two_lane_i,
  input  logic              msb_first_i,
  output logic [1:0]        lane_o
);

  localparam int WORD_W = DATA_W + PAD_W;
  localparam int EXT_W  = 1 << CNT_W;

  logic [WORD_W-1:0] ord;
  logic [EXT_W-1:0]  ord_ext;
  logic [CNT_W-2:0]  slot;
  logic [CNT_W-1:0]  idx0;
  logic [CNT_W-1:0]  idx1;

  for (genvar gj = 0; gj < WORD_W; gj++) begin : g_ord
    if (gj < DATA_W) begin : g_dat
      assign ord[gj] = msb_first_i ? word_i[DATA_W-1-gj] : word_i[gj];
    end else begin : g_pad
      assign ord[gj] = 1'b0;
    end
  end

  assign ord_ext   = EXT_W'(ord);
  assign slot      = cnt_i[CNT_W-1:1];
  assign idx0      = two_lane_i ? {slot, 1'b0} : {1'b0, slot};
  assign idx1      = {slot, 1'b1};
  assign lane_o[0] = ord_ext[idx0];
  assign lane_o[1] = two_lane_i & ord_ext[idx1];

  // R8
  lane_mid_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_i[0] |-> $stable(lane_o));

endmodule

// File: rtl/ls_sample_serializer.sv
`timescale 1ns/1ps
module ls_sample_serializer
  import lvser_pkg::*;
#(
  parameter int DATA_W  = LS_DATA_W,
  parameter int PAD_W   = LS_PAD_W,
  parameter int LATENCY = LS_LATENCY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din_i,
  input  logic              two_lane_i,
  input  logic              wide_i,
  input  logic              sdr_i,
  input  logic              rise_cap_i,
  input  logic              msb_first_i,
  output logic [1:0]        lane_o,
  output logic              bclk_o,
  output logic              frame_o
);

  localparam int WORD_W = DATA_W + PAD_W;
  localparam int CNT_W  = $clog2(2 * WORD_W);

  ser_mode_t         pin_mode;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic              act_two;
  logic              act_msb;
  logic              act_sdr;
  logic              act_rise;
  logic [DATA_W-1:0] word;

  assign pin_mode = {two_lane_i, wide_i, sdr_i, rise_cap_i, msb_first_i};

  ls_frame_timer #(.DATA_W(DATA_W), .PAD_W(PAD_W), .CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .mode_i(pin_mode),
    .cnt_o(cnt), .wrap_o(wrap), .frame_o(frame_o), .bclk_o(bclk_o),
    .two_lane_o(act_two), .msb_first_o(act_msb),
    .sdr_on_o(act_sdr), .rise_cap_o(act_rise)
  );

  ls_latency_pipe #(.DATA_W(DATA_W), .LATENCY(LATENCY)) pipe_i (
    .clk(clk), .rst(rst), .load_i(wrap), .din_i(din_i), .word_o(word)
  );

  ls_lane_select #(.DATA_W(DATA_W), .PAD_W(PAD_W), .CNT_W(CNT_W)) lanes_i (
    .clk(clk), .rst(rst), .word_i(word), .cnt_i(cnt),
    .two_lane_i(act_two), .msb_first_i(act_msb), .lane_o(lane_o)
  );

  // R9
  sdr_capture_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (act_sdr && (act_rise ? $rose(bclk_o) : $fell(bclk_o))) |-> $stable(lane_o));

endmodule

// File: tb/ls_sample_serializer_tb_top.sv
`timescale 1ns/1ps
module ls_sample_serializer_tb_top;
  import lvser_pkg::*;

  localparam int DW  = 14;
  localparam int LAT = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic          two_lane_i = 0, wide_i = 0, sdr_i = 0, rise_cap_i = 0, msb_first_i = 0;
  logic [1:0]    lane_o;
  logic          bclk_o, frame_o;

  int total = 0;
  int bad   = 0;
  int fidx, gcyc;
  ser_mode_t cur;
  logic [DW-1:0] hist [0:63];

  always #2.5 clk = ~clk;

  ls_sample_serializer dut_i (
    .clk(clk), .rst(rst), .din_i(din),
    .two_lane_i(two_lane_i), .wide_i(wide_i), .sdr_i(sdr_i),
    .rise_cap_i(rise_cap_i), .msb_first_i(msb_first_i),
    .lane_o(lane_o), .bclk_o(bclk_o), .frame_o(frame_o)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d (frame %0d)", tag, what, act, exp, fidx);
    end
  endtask

  function automatic ser_mode_t mk(bit two, bit wide, bit sdr, bit rise, bit msb);
    ser_mode_t m;
    m.two_lane = two; m.wide = wide; m.sdr = sdr; m.rise_cap = rise; m.msb_first = msb;
    return m;
  endfunction

  function automatic bit sbit(logic [DW-1:0] d, bit msb, int j);
    if (j >= DW) return 1'b0;
    return msb ? d[DW-1-j] : d[j];
  endfunction

  function automatic logic [DW-1:0] pat(int seed, int k);
    return DW'((k * 5419 + seed * 977 + 3) ^ 'h15A3);
  endfunction

  task automatic drive(ser_mode_t m);
    two_lane_i = m.two_lane; wide_i = m.wide; sdr_i = m.sdr;
    rise_cap_i = m.rise_cap; msb_first_i = m.msb_first;
  endtask

  task automatic do_reset(ser_mode_t m);
    @(negedge clk);
    rst = 1'b1;
    drive(m);
    din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cur = m; fidx = 0; gcyc = 0;
  endtask

  // runs one frame; early pins at cycle 0, late pins from cycle 2 on
  task automatic do_frame(logic [DW-1:0] d, ser_mode_t early, ser_mode_t late, string ltag);
    int p, wb, slot, ph;
    bit e0, e1, eb;
    logic [DW-1:0] ew;
    string tg;
    wb = cur.wide ? 16 : 14;
    p  = 2 * (cur.two_lane ? wb / 2 : wb);
    ew = (fidx >= LAT + 1) ? hist[fidx-LAT-1] : '0;
    tg = (fidx == LAT + 1) ? "R7" : ltag;
    hist[fidx] = d;
    din = d;
    drive(early);
    for (int c = 0; c < p; c++) begin
      if (c == 2) drive(late);
      slot = c / 2; ph = c % 2;
      if (cur.two_lane) begin
        e0 = sbit(ew, cur.msb_first, 2*slot);
        e1 = sbit(ew, cur.msb_first, 2*slot + 1);
      end else begin
        e0 = sbit(ew, cur.msb_first, slot);
        e1 = 1'b0;
      end
      check(lane_o == {e1, e0}, tg, "lanes", int'(lane_o), int'({e1, e0}));
      check(frame_o == (c < p/2), "R2", "frame_o", int'(frame_o), int'(c < p/2));
      if (cur.sdr && cur.two_lane) begin
        eb = cur.rise_cap ? ph[0] : !ph[0];
        check(bclk_o == eb, "R9", "bclk_o", int'(bclk_o), int'(eb));
      end else begin
        eb = ((gcyc + 1) / 2) % 2;
        check(bclk_o == eb, "R8", "bclk_o", int'(bclk_o), int'(eb));
      end
      gcyc++;
      @(negedge clk);
    end
    cur = late;
    fidx++;
  endtask

  task automatic run_fixed(ser_mode_t m, int seed, string ltag);
    do_reset(m);
    for (int k = 0; k < 20; k++) do_frame(pat(seed, k), m, m, ltag);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1'b1;
    drive(mk(1, 1, 1, 0, 1));
    din = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(lane_o == 2'b00, "R1", "lanes in reset", int'(lane_o), 0);
    check(frame_o == 1'b1, "R1", "frame in reset", int'(frame_o), 1);
  endtask

  task automatic test_one_lane_msb();   run_fixed(mk(0, 0, 0, 0, 1), 1, "R3"); endtask
  task automatic test_one_lane_wide();  run_fixed(mk(0, 1, 0, 0, 0), 2, "R6"); endtask
  task automatic test_two_lane_ddr();   run_fixed(mk(1, 0, 0, 0, 1), 3, "R4"); endtask
  task automatic test_two_lane_lsb();   run_fixed(mk(1, 0, 1, 1, 0), 4, "R5"); endtask
  task automatic test_sdr_fall_wide();  run_fixed(mk(1, 1, 1, 0, 1), 5, "R9"); endtask
  task automatic test_sdr_one_lane();   run_fixed(mk(0, 0, 1, 1, 1), 6, "R8"); endtask

  task automatic test_mode_switch();
    ser_mode_t ml [4];
    ml[0] = mk(0, 0, 0, 0, 1);
    ml[1] = mk(1, 1, 1, 1, 0);
    ml[2] = mk(1, 0, 1, 0, 1);
    ml[3] = mk(0, 1, 0, 1, 0);
    do_reset(ml[0]);
    for (int k = 0; k < 24; k++)
      do_frame(pat(7, k), ml[(k + 2) % 4], ml[(k + 1) % 4], "R10");
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL R2 watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fidx = 0; gcyc = 0;
    test_reset();
    test_one_lane_msb();
    test_one_lane_wide();
    test_two_lane_ddr();
    test_two_lane_lsb();
    test_sdr_fall_wide();
    test_sdr_one_lane();
    test_mode_switch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule